// File: doc/BRIEF.md
# Mode-Dependent Multiplexed GPIO Port

This block is an eight-pin microcontroller I/O port. Software sees two registers on a small register bus: a data register that holds output values and a direction register that holds one output-enable bit for each pin. The operating mode decides who owns each pin. In the bus-expanded modes, four pins carry the strobes of an external bus controller. Three more pins can each be handed to a bus-arbitration or wait function. In the single-chip modes, every pin below the top one is plain GPIO. The top pin carries the system clock out unless a clock-stop bit turns it into an input.

Read-back follows fixed rules. The direction register cannot be read back and always returns all ones. A data-register read returns the stored value for output pins and the synchronized pin level for input pins. The top bit returns either a constant one or the pin level, depending on the clock-stop bit. Reset and hardware standby load both registers with 0x80. Software standby freezes both registers, so pins that were driving keep their values.

Top module: `pinmux_port`

## Requirements
- R1: A synchronous reset (rst_n low) or an asserted hw_stby loads the data register and the direction register with 0x80. Right after reset, in mode 7 with clk_stop=0, the outputs are pin_oe=0x80 and pin_out={sys_clk_in,7'b0}.
- R2: In every mode, pin 7 has pin_oe[7]=!clk_stop and drives sys_clk_in while enabled.
- R3: In modes 0 to 5 (the expanded modes), pins 6,5,4,3 are always enabled and drive bc_lwr_n, bc_hwr_n, bc_rd_n and bc_as_n, in that order, whatever the direction register holds.
- R4: In the expanded modes, arb_en_back gives pin 2 to the bus controller, which then drives bc_back_n on it. arb_en_breq makes pin 1 an input and arb_en_wait makes pin 0 an input. A pin whose enable is low is GPIO.
- R5: In modes 6 and 7, pins 6 to 0 are GPIO and the arbitration enables are ignored. On a GPIO pin, pin_oe equals the direction bit and pin_out equals the data bit. On every pin, pin_out is 0 whenever pin_oe is 0.
- R6: A read at reg_addr=1 (the direction register) returns 0xFF.
- R7: A read at reg_addr=0 (the data register) returns 1 in bit 7 when clk_stop=0, and the synchronized level of pin 7 when clk_stop=1.
- R8: In a data-register read, each of bits 6 to 0 returns the stored data bit if its direction bit is 1, and the synchronized pin level if its direction bit is 0.
- R9: Read data appears on reg_rdata in the cycle after the edge that samples reg_rd, and is 0 in all other cycles. A pin change made before edge k is still absent from a read sampled at edge k+1 and is present in a read sampled at edge k+2.
- R10: While sw_stby is high, register writes are ignored, and pin_oe and pin_out keep their values.
- R11: Reads at reg_addr 2 and 3 return 0. Writes to those addresses change nothing.
- R12: A write sampled at a clock edge shows on pin_oe and pin_out right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; reinitializes the registers |
| sw_stby | input | 1 | Software standby; freezes the registers |
| op_mode | input | 3 | Operating mode; 0 to 5 expanded, 6 and 7 single-chip |
| clk_stop | input | 1 | 1 stops the clock output on pin 7 |
| sys_clk_in | input | 1 | System clock level to be driven on pin 7 |
| bc_lwr_n | input | 1 | Low-byte write strobe from the bus controller |
| bc_hwr_n | input | 1 | High-byte write strobe from the bus controller |
| bc_rd_n | input | 1 | Read strobe from the bus controller |
| bc_as_n | input | 1 | Address strobe from the bus controller |
| bc_back_n | input | 1 | Bus acknowledge from the bus controller |
| arb_en_back | input | 1 | Gives pin 2 to bus acknowledge |
| arb_en_breq | input | 1 | Gives pin 1 to bus request |
| arb_en_wait | input | 1 | Gives pin 0 to wait |
| reg_addr | input | 2 | Register select: 0 data, 1 direction |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
Pin ownership and output values are combinational from the mode inputs and the registers. The bench therefore checks pin_oe and pin_out at the falling edge that follows the edge taking the last register write, and after a short settle delay when only a mode input changed. Read data is registered: each read is sampled at the falling edge one cycle after the strobe was raised. Pin levels pass through two flops first. The bench holds a read strobe over the second and third edges after a pin change and expects the old level in the first result and the new level in the second.

// File: rtl/pinmux_pkg.sv
// Shared sizes, encodings and reset values for the multiplexed port.
// Assumes an 8-pin port: 1 clock pin, 4 strobe pins, 3 arbitration pins.
package pinmux_pkg;
    localparam int PORT_W      = 8;
    localparam int MODE_W      = 3;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int STRB_W      = 4;
    localparam int ARB_W       = 3;

    localparam logic [MODE_W-1:0] FIRST_SINGLE_MODE = 3'd6;
    localparam logic [PORT_W-1:0] INIT_VAL          = 8'h80;
    localparam logic [ADDR_W-1:0] ADDR_DATA         = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR          = 2'd1;

    typedef enum logic [1:0] {
        OWN_GPIO    = 2'd0,
        OWN_BUS_OUT = 2'd1,
        OWN_BUS_IN  = 2'd2
    } pin_owner_e;
endpackage

// File: rtl/pm_regfile.sv
// Data and direction storage for pins below the clock pin.
// Assumes sync active-low reset; hw_stby reinitializes, sw_stby freezes.
// Bit 7 of both registers is fixed and not stored.
module pm_regfile
    import pinmux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-2:0]  dat_q,
    output logic [W-2:0]  dir_q
);
    logic unused_wdata_msb;
    assign unused_wdata_msb = wdata[W-1];

    // Register update: init on reset or hard standby, frozen in soft standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            dat_q <= INIT_VAL[W-2:0];
            dir_q <= INIT_VAL[W-2:0];
        end else if (wr_en && !sw_stby) begin
            if (addr == ADDR_DATA) dat_q <= wdata[W-2:0];
            if (addr == ADDR_DIR)  dir_q <= wdata[W-2:0];
        end
    end

    AST_HARD_STBY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dat_q == INIT_VAL[W-2:0]) && (dir_q == INIT_VAL[W-2:0])); // R1
    AST_SOFT_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> ($stable(dat_q) && $stable(dir_q))); // R10
    AST_UNDECODED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hw_stby && addr != ADDR_DATA && addr != ADDR_DIR)
        |=> ($stable(dat_q) && $stable(dir_q))); // R11
endmodule

// File: rtl/pm_sync.sv
// Multi-stage synchronizer for pad input levels.
// Assumes pads are asynchronous to clk; stage count is a parameter.
module pm_sync
    import pinmux_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Later stage: shift from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pm_pinmux.sv
// Chooses owner, output value and output enable of every pin from the mode.
// Pin 7 is the clock pin; pins 6..3 are strobes and 2..0 arbitration in
// expanded modes; everything below pin 7 is GPIO in single-chip modes.
module pm_pinmux
    import pinmux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int SW = STRB_W,
    parameter int AW = ARB_W
) (
    input  logic [MODE_W-1:0] op_mode,
    input  logic              clk_stop,
    input  logic              sys_clk_in,
    input  logic [SW-1:0]     strobes,
    input  logic              ack_out,
    input  logic [AW-1:0]     arb_en,
    input  logic [W-2:0]      dat_q,
    input  logic [W-2:0]      dir_q,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    logic         expanded;
    logic [W-1:0] oe_vec;
    logic [W-1:0] val_vec;

    assign expanded = (op_mode < FIRST_SINGLE_MODE);

    for (genvar i = 0; i < W - 1; i++) begin : g_pin
        pin_owner_e own;
        logic       busv;
        if (i < AW) begin : g_arb
            // Arbitration pin: top one is the acknowledge output, rest are inputs.
            always_comb begin
                own  = OWN_GPIO;
                busv = 1'b0;
                if (expanded && arb_en[i]) begin
                    own  = (i == AW - 1) ? OWN_BUS_OUT : OWN_BUS_IN;
                    busv = (i == AW - 1) ? ack_out : 1'b0;
                end
            end
        end else begin : g_strb
            // Strobe pin: owned by the bus controller in every expanded mode.
            always_comb begin
                own  = expanded ? OWN_BUS_OUT : OWN_GPIO;
                busv = expanded ? strobes[i-AW] : 1'b0;
            end
        end
        // Per-pin output stage from the selected owner.
        always_comb begin
            unique case (own)
                OWN_BUS_OUT: begin oe_vec[i] = 1'b1;     val_vec[i] = busv;     end
                OWN_BUS_IN:  begin oe_vec[i] = 1'b0;     val_vec[i] = 1'b0;     end
                default:     begin oe_vec[i] = dir_q[i]; val_vec[i] = dat_q[i]; end
            endcase
        end
    end

    assign oe_vec[W-1]  = !clk_stop;
    assign val_vec[W-1] = sys_clk_in;

    assign pin_oe  = oe_vec;
    assign pin_out = val_vec & oe_vec;
endmodule

// File: rtl/pm_readback.sv
// Registered read path: data-register view, all-ones direction view,
// zero for undecoded addresses and for idle cycles.
module pm_readback
    import pinmux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic          clk_stop,
    input  logic [W-2:0]  dat_q,
    input  logic [W-2:0]  dir_q,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] dat_view;

    // Data-register view: stored bit for outputs, pin level for inputs.
    always_comb begin
        dat_view[W-1] = clk_stop ? pin_sync[W-1] : 1'b1;
        for (int b = 0; b < W - 1; b++)
            dat_view[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
    end

    // Read register: one-cycle result of a sampled read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (!rd_en)     rdata <= '0;
        else if (addr == ADDR_DATA) rdata <= dat_view;
        else if (addr == ADDR_DIR)  rdata <= '1;
        else                 rdata <= '0;
    end

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_DIR) |=> (rdata == '1)); // R6
    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_DIR && addr != ADDR_DATA) |=> (rdata == '0)); // R11
    AST_CLK_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_DATA && !clk_stop) |=> rdata[W-1]); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0)); // R9
endmodule

// File: rtl/pinmux_port.sv
// Top of the mode-dependent multiplexed port: register bus, pad
// synchronizer, pin ownership and read-back. Sync active-low reset.
module pinmux_port
    import pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] op_mode,
    input  logic              clk_stop,
    input  logic              sys_clk_in,
    input  logic              bc_lwr_n,
    input  logic              bc_hwr_n,
    input  logic              bc_rd_n,
    input  logic              bc_as_n,
    input  logic              bc_back_n,
    input  logic              arb_en_back,
    input  logic              arb_en_breq,
    input  logic              arb_en_wait,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic [PORT_W-2:0] dat_q;
    logic [PORT_W-2:0] dir_q;
    logic [PORT_W-1:0] pin_sync;
    logic [STRB_W-1:0] strobes;
    logic [ARB_W-1:0]  arb_en;

    assign strobes = {bc_lwr_n, bc_hwr_n, bc_rd_n, bc_as_n};
    assign arb_en  = {arb_en_back, arb_en_breq, arb_en_wait};

    pm_regfile #(.W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .dat_q(dat_q), .dir_q(dir_q)
    );

    pm_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    pm_pinmux #(.W(PORT_W), .SW(STRB_W), .AW(ARB_W)) u_mux (
        .op_mode(op_mode), .clk_stop(clk_stop), .sys_clk_in(sys_clk_in),
        .strobes(strobes), .ack_out(bc_back_n), .arb_en(arb_en),
        .dat_q(dat_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    pm_readback #(.W(PORT_W), .AW(ADDR_W)) u_rdbk (
        .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(reg_addr),
        .clk_stop(clk_stop), .dat_q(dat_q), .dir_q(dir_q),
        .pin_sync(pin_sync), .rdata(reg_rdata)
    );

    AST_CLOCK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[PORT_W-1] != clk_stop) &&
        (!pin_oe[PORT_W-1] || pin_out[PORT_W-1] == sys_clk_in)); // R2
    AST_STROBE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode < FIRST_SINGLE_MODE) |->
        (pin_oe[6:3] == 4'hF) && (pin_out[6:3] == strobes)); // R3
    AST_ARB_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode < FIRST_SINGLE_MODE) |->
        (!(arb_en_breq && pin_oe[1]) && !(arb_en_wait && pin_oe[0]))); // R4
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R5
    AST_STBY_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && $stable(op_mode) && $stable(clk_stop) &&
         $stable(sys_clk_in) && $stable(strobes) && $stable(arb_en) &&
         $stable(bc_back_n)) |=> ($stable(pin_oe) && $stable(pin_out))); // R10
endmodule

// File: tb/pinmux_port_tb.sv
module pinmux_port_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0] mode;
        logic       stop;
        logic [2:0] en;     // {back, breq, wait}
        logic [7:0] dir;
        logic [7:0] dat;
        logic [3:0] strb;   // {lwr, hwr, rd, as}
        logic       back;
        logic       sclk;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd7, 1'b0, 3'b000, 8'h55, 8'h3C, 4'b1010, 1'b1, 1'b1, 8'hD5, 8'h94},
        '{3'd2, 1'b0, 3'b000, 8'h05, 8'h7E, 4'b1011, 1'b0, 1'b0, 8'hFD, 8'h5C},
        '{3'd5, 1'b1, 3'b111, 8'h00, 8'h00, 4'b0101, 1'b1, 1'b1, 8'h7C, 8'h2C},
        '{3'd1, 1'b0, 3'b101, 8'h07, 8'h03, 4'b0000, 1'b0, 1'b1, 8'hFE, 8'h82},
        '{3'd6, 1'b1, 3'b111, 8'h7F, 8'h2A, 4'b1111, 1'b1, 1'b1, 8'h7F, 8'h2A},
        '{3'd0, 1'b0, 3'b010, 8'h00, 8'h00, 4'b1100, 1'b1, 1'b0, 8'hF8, 8'h60}
    };

    logic clk = 1'b0;
    logic rst_n, hw_stby, sw_stby, clk_stop, sys_clk_in;
    logic [2:0] op_mode;
    logic bc_lwr_n, bc_hwr_n, bc_rd_n, bc_as_n, bc_back_n;
    logic arb_en_back, arb_en_breq, arb_en_wait;
    logic [1:0] reg_addr;
    logic reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata, pin_in, pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinmux_port u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .op_mode(op_mode), .clk_stop(clk_stop), .sys_clk_in(sys_clk_in),
        .bc_lwr_n(bc_lwr_n), .bc_hwr_n(bc_hwr_n), .bc_rd_n(bc_rd_n),
        .bc_as_n(bc_as_n), .bc_back_n(bc_back_n),
        .arb_en_back(arb_en_back), .arb_en_breq(arb_en_breq),
        .arb_en_wait(arb_en_wait), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; op_mode = 3'd7;
        clk_stop = 1'b0; sys_clk_in = 1'b1;
        {bc_lwr_n, bc_hwr_n, bc_rd_n, bc_as_n, bc_back_n} = 5'b11111;
        {arb_en_back, arb_en_breq, arb_en_wait} = 3'b000;
        reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset oe", pin_oe, 8'h80);
        check("R1 reset out", pin_out, 8'h80);
        check("R9 idle rdata", reg_rdata, 8'h00);

        // Table walk: R3 R4 R5 R2 R12
        for (int i = 0; i < NV; i++) begin
            op_mode = VECS[i].mode; clk_stop = VECS[i].stop;
            {arb_en_back, arb_en_breq, arb_en_wait} = VECS[i].en;
            {bc_lwr_n, bc_hwr_n, bc_rd_n, bc_as_n} = VECS[i].strb;
            bc_back_n = VECS[i].back; sys_clk_in = VECS[i].sclk;
            write_reg(2'd1, VECS[i].dir);
            write_reg(2'd0, VECS[i].dat);
            check($sformatf("R3/R4/R5/R12 vec%0d oe", i), pin_oe, VECS[i].exp_oe);
            check($sformatf("R3/R4/R5/R12 vec%0d out", i), pin_out, VECS[i].exp_out);
        end

        // R2: clock pin follows sys_clk_in
        op_mode = 3'd7; clk_stop = 1'b0; sys_clk_in = 1'b0;
        #1 check("R2 clk low", {7'b0, pin_out[7]}, 8'h00);
        sys_clk_in = 1'b1;
        #1 check("R2 clk high", {7'b0, pin_out[7]}, 8'h01);

        // R6: direction register reads all ones
        write_reg(2'd1, 8'h00);
        read_reg(2'd1, rv);
        check("R6 dir read", rv, 8'hFF);

        // R8: mixed direction readback
        write_reg(2'd1, 8'h0F);
        write_reg(2'd0, 8'h55);
        pin_in = 8'hA6;
        repeat (3) @(negedge clk);
        read_reg(2'd0, rv);
        check("R8 mixed read", rv, 8'hA5);

        // R7: bit 7 reflects pin level when the clock is stopped
        clk_stop = 1'b1;
        write_reg(2'd1, 8'h7F);
        write_reg(2'd0, 8'h11);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        read_reg(2'd0, rv);
        check("R7 stop pin low", rv, 8'h11);
        pin_in = 8'h80;
        repeat (3) @(negedge clk);
        read_reg(2'd0, rv);
        check("R7 stop pin high", rv, 8'h91);
        clk_stop = 1'b0;

        // R9: two-flop delay on pin levels
        write_reg(2'd1, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h01;
        @(negedge clk);
        reg_addr = 2'd0; reg_rd = 1'b1;
        @(negedge clk);
        check("R9 second edge old", reg_rdata, 8'h80);
        @(negedge clk);
        check("R9 third edge new", reg_rdata, 8'h81);
        reg_rd = 1'b0;

        // R10: software standby freezes registers and pins
        write_reg(2'd1, 8'h7F);
        write_reg(2'd0, 8'h12);
        check("R10 before oe", pin_oe, 8'hFF);
        sw_stby = 1'b1;
        write_reg(2'd0, 8'h55);
        write_reg(2'd1, 8'h00);
        check("R10 stby oe", pin_oe, 8'hFF);
        check("R10 stby out", pin_out, 8'h92);
        sw_stby = 1'b0;

        // R11: undecoded addresses
        read_reg(2'd2, rv);
        check("R11 read addr2", rv, 8'h00);
        write_reg(2'd3, 8'h00);
        check("R11 write addr3 oe", pin_oe, 8'hFF);
        read_reg(2'd0, rv);
        check("R11 data intact", rv, 8'h92);

        // R1: hardware standby reinitializes both registers
        @(negedge clk);
        hw_stby = 1'b1;
        @(negedge clk);
        hw_stby = 1'b0;
        check("R1 hw stby oe", pin_oe, 8'h80);
        write_reg(2'd1, 8'h7F);
        check("R1 hw stby data", pin_out, 8'h80);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule